// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block is the hazard gate in front of a single-issue, in-order pipeline that feeds several functional units of differing latency. Each cycle, decode presents at most one instruction: the class of functional unit it needs, an optional destination register and up to two optional source registers. The scoreboard answers in the same cycle with a grant (the instruction dispatches at the next clock edge) or a stall (decode holds the instruction and presents it again).

Two bit-vectors hold all the state. The first has one busy flag per functional-unit class. A flag is raised when an instruction dispatches to that unit and dropped when the unit pulses its release line. The second has one write-pending flag per architectural register. It is raised on dispatch for the destination and dropped by the writeback port.

A release or writeback that arrives in the same cycle as a check already counts in that check. Because issue is strictly in program order, a later instruction can never write a register before an earlier one has read it, so no write-after-read tracking is kept.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every busy flag and every pending flag is clear, so the first valid instruction is granted whatever its unit and registers.
- R2: Unit classes are encoded int=0, fp-add=1, fp-mul=2, fp-div=3. A granted instruction marks its unit busy, and a later instruction for that unit stalls until the unit releases it.
- R3: An instruction stalls (RAW) while either enabled source register has a write pending.
- R4: An instruction stalls (WAW) while its enabled destination register has a write pending.
- R5: A register that is only read by an in-flight instruction may be written by a new instruction without stalling; there is no WAR check.
- R6: A source or destination whose enable flag is low takes no part in any hazard check, and a granted instruction whose destination is disabled marks no register pending.
- R7: A writeback clears its register's pending flag, and an instruction checked in that same cycle already sees the flag as clear.
- R8: A release pulse clears its unit's busy flag, and an instruction checked in that same cycle already sees the unit as free.
- R9: When a granted instruction's destination equals the register written back in that cycle, the register is left pending.
- R10: grant_o and stall_o are never high together; with instr_valid_i low both are low; with it high exactly one is high. At most one instruction dispatches per cycle.
- R11: An instruction presented with instr_valid_i low changes neither the pending flags nor the busy flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Decode presents an instruction |
| instr_unit_i | input | UNIT_W | Functional-unit class of the instruction |
| instr_dst_i | input | REG_W | Destination register |
| instr_dst_en_i | input | 1 | Instruction writes a destination |
| instr_src1_i | input | REG_W | First source register |
| instr_src1_en_i | input | 1 | First source is used |
| instr_src2_i | input | REG_W | Second source register |
| instr_src2_en_i | input | 1 | Second source is used |
| unit_release_i | input | NUM_UNITS | Per-unit pulse: unit is free again |
| wb_valid_i | input | 1 | A writeback happens this cycle |
| wb_reg_i | input | REG_W | Register being written back |
| grant_o | output | 1 | Instruction dispatches at the next edge |
| stall_o | output | 1 | Instruction is held by a hazard |

## Verification
Dispatch and writeback can fall in the same cycle, and so can dispatch and unit release. Directed steps drive a writeback or a release on exactly the register or unit that would otherwise block the presented instruction. One step also sets the new destination equal to the register being written back. The result is judged in two ways: by the grant in that cycle, and by whether a following reader of that register stalls. A long random phase over a small register window makes such collisions frequent. Every cycle, it compares grant and stall against a behavioural model that applies clear-then-set ordering.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned NUM_UNITS_DEF = 4;
  localparam int unsigned NUM_REGS_DEF  = 32;

  typedef enum logic [1:0] {
    UNIT_INT  = 2'd0,
    UNIT_FADD = 2'd1,
    UNIT_FMUL = 2'd2,
    UNIT_FDIV = 2'd3
  } unit_class_e;
endpackage

// File: rtl/sb_pend_table.sv
module sb_pend_table #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [REG_W-1:0]    set_reg_i,
  input  logic                clr_i,
  input  logic [REG_W-1:0]    clr_reg_i,
  output logic [NUM_REGS-1:0] pend_eff_o
);
  logic [NUM_REGS-1:0] pend_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic set_hit, clr_hit;
    assign set_hit = set_i && (set_reg_i == REG_W'(r));
    assign clr_hit = clr_i && (clr_reg_i == REG_W'(r));
    // same-cycle writeback already counts as cleared
    assign pend_eff_o[r] = pend_q[r] && !clr_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q[r] <= 1'b0;
      else if (set_hit) pend_q[r] <= 1'b1;   // set wins over clear
      else if (clr_hit) pend_q[r] <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_unit_tracker.sv
module sb_unit_tracker #(
  parameter int unsigned NUM_UNITS = 4,
  localparam int unsigned UNIT_W = $clog2(NUM_UNITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_i,
  input  logic [UNIT_W-1:0]    alloc_unit_i,
  input  logic [NUM_UNITS-1:0] release_i,
  output logic [NUM_UNITS-1:0] busy_eff_o
);
  logic [NUM_UNITS-1:0] busy_q;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic alloc_hit;
    assign alloc_hit     = alloc_i && (alloc_unit_i == UNIT_W'(u));
    assign busy_eff_o[u] = busy_q[u] && !release_i[u];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           busy_q[u] <= 1'b0;
      else if (alloc_hit)    busy_q[u] <= 1'b1;
      else if (release_i[u]) busy_q[u] <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned NUM_UNITS = 4,
  localparam int unsigned REG_W  = $clog2(NUM_REGS),
  localparam int unsigned UNIT_W = $clog2(NUM_UNITS)
) (
  input  logic                 valid_i,
  input  logic [UNIT_W-1:0]    unit_i,
  input  logic [REG_W-1:0]     dst_i,
  input  logic                 dst_en_i,
  input  logic [REG_W-1:0]     src1_i,
  input  logic                 src1_en_i,
  input  logic [REG_W-1:0]     src2_i,
  input  logic                 src2_en_i,
  input  logic [NUM_REGS-1:0]  pend_eff_i,
  input  logic [NUM_UNITS-1:0] busy_eff_i,
  output logic                 grant_o,
  output logic                 stall_o
);
  function automatic logic reg_pending(input logic [REG_W-1:0] idx,
                                       input logic [NUM_REGS-1:0] vec);
    if (int'(idx) < int'(NUM_REGS)) return vec[idx];
    return 1'b1;  // unknown register: hold
  endfunction

  logic unit_block, raw_block, waw_block;

  always_comb begin
    unit_block = (int'(unit_i) < int'(NUM_UNITS)) ? busy_eff_i[unit_i] : 1'b1;
    raw_block  = (src1_en_i && reg_pending(src1_i, pend_eff_i)) ||
                 (src2_en_i && reg_pending(src2_i, pend_eff_i));
    waw_block  = dst_en_i && reg_pending(dst_i, pend_eff_i);
    grant_o    = valid_i && !unit_block && !raw_block && !waw_block;
    stall_o    = valid_i && !grant_o;
  end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int unsigned NUM_REGS  = sb_pkg::NUM_REGS_DEF,
  parameter int unsigned NUM_UNITS = sb_pkg::NUM_UNITS_DEF,
  localparam int unsigned REG_W  = $clog2(NUM_REGS),
  localparam int unsigned UNIT_W = $clog2(NUM_UNITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 instr_valid_i,
  input  logic [UNIT_W-1:0]    instr_unit_i,
  input  logic [REG_W-1:0]     instr_dst_i,
  input  logic                 instr_dst_en_i,
  input  logic [REG_W-1:0]     instr_src1_i,
  input  logic                 instr_src1_en_i,
  input  logic [REG_W-1:0]     instr_src2_i,
  input  logic                 instr_src2_en_i,
  input  logic [NUM_UNITS-1:0] unit_release_i,
  input  logic                 wb_valid_i,
  input  logic [REG_W-1:0]     wb_reg_i,
  output logic                 grant_o,
  output logic                 stall_o
);
  logic [NUM_REGS-1:0]  pend_eff;
  logic [NUM_UNITS-1:0] busy_eff;
  logic                 grant;

  sb_pend_table #(.NUM_REGS(NUM_REGS)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (grant && instr_dst_en_i),
    .set_reg_i  (instr_dst_i),
    .clr_i      (wb_valid_i),
    .clr_reg_i  (wb_reg_i),
    .pend_eff_o (pend_eff)
  );

  sb_unit_tracker #(.NUM_UNITS(NUM_UNITS)) u_units (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (grant),
    .alloc_unit_i (instr_unit_i),
    .release_i    (unit_release_i),
    .busy_eff_o   (busy_eff)
  );

  sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)) u_check (
    .valid_i    (instr_valid_i),
    .unit_i     (instr_unit_i),
    .dst_i      (instr_dst_i),
    .dst_en_i   (instr_dst_en_i),
    .src1_i     (instr_src1_i),
    .src1_en_i  (instr_src1_en_i),
    .src2_i     (instr_src2_i),
    .src2_en_i  (instr_src2_en_i),
    .pend_eff_i (pend_eff),
    .busy_eff_i (busy_eff),
    .grant_o    (grant),
    .stall_o    (stall_o)
  );

  assign grant_o = grant;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned NUM_UNITS = 4,
  localparam int unsigned REG_W  = $clog2(NUM_REGS),
  localparam int unsigned UNIT_W = $clog2(NUM_UNITS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 instr_valid_i,
  input logic [UNIT_W-1:0]    instr_unit_i,
  input logic [REG_W-1:0]     instr_dst_i,
  input logic                 instr_dst_en_i,
  input logic [REG_W-1:0]     instr_src1_i,
  input logic                 instr_src1_en_i,
  input logic [NUM_UNITS-1:0] unit_release_i,
  input logic                 wb_valid_i,
  input logic [REG_W-1:0]     wb_reg_i,
  input logic                 grant_o,
  input logic                 stall_o
);
  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && stall_o));

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> !(grant_o || stall_o));

  a_r2_unit_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> (!(instr_valid_i && instr_unit_i == $past(instr_unit_i) &&
                   !unit_release_i[$past(instr_unit_i)]) || stall_o));

  a_r4_waw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && instr_dst_en_i) |=>
      (!(instr_valid_i && instr_dst_en_i && instr_dst_i == $past(instr_dst_i) &&
         !(wb_valid_i && wb_reg_i == $past(instr_dst_i))) || stall_o));

  a_r3_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && instr_dst_en_i) |=>
      (!(instr_valid_i && instr_src1_en_i && instr_src1_i == $past(instr_dst_i) &&
         !(wb_valid_i && wb_reg_i == $past(instr_dst_i))) || stall_o));
endmodule

bind issue_scoreboard sb_checker #(.NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)) u_sb_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .instr_valid_i   (instr_valid_i),
  .instr_unit_i    (instr_unit_i),
  .instr_dst_i     (instr_dst_i),
  .instr_dst_en_i  (instr_dst_en_i),
  .instr_src1_i    (instr_src1_i),
  .instr_src1_en_i (instr_src1_en_i),
  .unit_release_i  (unit_release_i),
  .wb_valid_i      (wb_valid_i),
  .wb_reg_i        (wb_reg_i),
  .grant_o         (grant_o),
  .stall_o         (stall_o)
);

// File: tb/tb_issue_scoreboard.sv
module tb_issue_scoreboard;
  localparam int NREG = 32;
  localparam int NUNIT = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       instr_valid_i = 1'b0;
  logic [1:0] instr_unit_i = '0;
  logic [4:0] instr_dst_i = '0, instr_src1_i = '0, instr_src2_i = '0, wb_reg_i = '0;
  logic       instr_dst_en_i = 1'b0, instr_src1_en_i = 1'b0, instr_src2_en_i = 1'b0;
  logic [3:0] unit_release_i = '0;
  logic       wb_valid_i = 1'b0;
  logic       grant_o, stall_o;

  int checks = 0;
  int errors = 0;
  bit pend [NREG];
  bit busy [NUNIT];

  always #2 clk_i = ~clk_i;

  issue_scoreboard dut (.*);

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic bit model_grant();
    bit ub, blk;
    if (!instr_valid_i) return 1'b0;
    ub = busy[instr_unit_i] && !unit_release_i[instr_unit_i];
    blk = ub;
    if (instr_src1_en_i && pend[instr_src1_i] && !(wb_valid_i && wb_reg_i == instr_src1_i)) blk = 1;
    if (instr_src2_en_i && pend[instr_src2_i] && !(wb_valid_i && wb_reg_i == instr_src2_i)) blk = 1;
    if (instr_dst_en_i && pend[instr_dst_i] && !(wb_valid_i && wb_reg_i == instr_dst_i)) blk = 1;
    return !blk;
  endfunction

  // drive, compare, then advance model across the clock edge
  task automatic step(input string tag, input bit v, input int unit, input int dst, input bit den,
                      input int s1, input bit s1en, input int s2, input bit s2en,
                      input logic [3:0] rel, input bit wbv, input int wbr);
    bit eg, es;
    instr_valid_i = v; instr_unit_i = 2'(unit);
    instr_dst_i = 5'(dst); instr_dst_en_i = den;
    instr_src1_i = 5'(s1); instr_src1_en_i = s1en;
    instr_src2_i = 5'(s2); instr_src2_en_i = s2en;
    unit_release_i = rel; wb_valid_i = wbv; wb_reg_i = 5'(wbr);
    #1;
    eg = model_grant();
    es = v && !eg;
    checks++;
    if (grant_o !== eg || stall_o !== es) begin
      errors++;
      $display("FAIL %s: grant/stall actual %b/%b expected %b/%b", tag, grant_o, stall_o, eg, es);
    end
    @(posedge clk_i);
    for (int u = 0; u < NUNIT; u++) if (rel[u]) busy[u] = 0;
    if (wbv) pend[wbr] = 0;
    if (eg) begin
      busy[unit] = 1;
      if (den) pend[dst] = 1;
    end
    @(negedge clk_i);
  endtask

  initial begin
    for (int r = 0; r < NREG; r++) pend[r] = 0;
    for (int u = 0; u < NUNIT; u++) busy[u] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 4'b0, 0, 0);        // idle: neither
    step("R1",  1, 0, 1, 1, 2, 1, 3, 1, 4'b0, 0, 0);        // int, dst r1
    step("R2",  1, 0, 4, 1, 9, 0, 9, 0, 4'b0, 0, 0);        // int busy -> stall
    step("R8",  1, 0, 4, 1, 9, 0, 9, 0, 4'b0001, 0, 0);     // release same cycle -> grant
    step("R3",  1, 1, 5, 1, 1, 1, 9, 0, 4'b0, 0, 0);        // src1 r1 pending
    step("R3",  1, 1, 5, 1, 2, 1, 4, 1, 4'b0, 0, 0);        // src2 r4 pending
    step("R6",  1, 1, 5, 1, 1, 0, 4, 0, 4'b0, 0, 0);        // sources masked -> grant
    step("R4",  1, 2, 5, 1, 9, 0, 9, 0, 4'b0, 0, 0);        // dst r5 pending
    step("R6",  1, 2, 5, 0, 9, 0, 9, 0, 4'b0, 0, 0);        // dst masked -> grant
    step("R6",  1, 3, 6, 0, 5, 0, 9, 0, 4'b0, 0, 0);        // r5 write had no dst effect? (masked src)
    step("R7",  1, 0, 7, 1, 1, 1, 9, 0, 4'b0001, 1, 1);     // wb r1 same cycle -> grant
    step("R9",  1, 0, 4, 1, 9, 0, 9, 0, 4'b0001, 1, 4);     // wb r4 + new dst r4
    step("R9",  1, 0, 8, 1, 4, 1, 9, 0, 4'b0001, 0, 0);     // r4 still pending -> stall
    step("R5",  1, 0, 2, 1, 9, 0, 9, 0, 4'b0001, 0, 0);     // write r2, read by in-flight
    step("R11", 0, 1, 10, 1, 9, 0, 9, 0, 4'b0011, 0, 0);    // invalid, dst r10
    step("R11", 1, 1, 11, 1, 10, 1, 9, 0, 4'b0, 0, 0);      // r10 not pending, fadd free
    step("R2",  1, 3, 12, 0, 9, 0, 9, 0, 4'b0, 0, 0);       // fdiv busy from earlier

    for (int i = 0; i < 3000; i++) begin
      int wr;
      bit wv;
      wr = $urandom_range(0, 7);
      wv = pend[wr] && ($urandom_range(0, 2) == 0);
      step("R10", $urandom_range(0, 3) != 0, $urandom_range(0, 3),
           $urandom_range(0, 7), $urandom_range(0, 4) != 0,
           $urandom_range(0, 7), $urandom_range(0, 1) == 1,
           $urandom_range(0, 7), $urandom_range(0, 1) == 1,
           4'($urandom_range(0, 15) & $urandom_range(0, 15)), wv, wr);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule